// File: doc/BRIEF.md
# Multi-channel acquisition packet assembler

This block gathers samples from four converter channels (two dual-channel converters) and turns them into fixed 160-bit packets for a host streaming link. A packet carries a 32-bit frame number followed by two time-consecutive samples from every channel. The packet leaves the block as five 32-bit words under valid/ready flow control. From gaps in the frame number, the host can tell that packets were lost.

Each strobe on `smp_valid` delivers one sample instant for all channels at once. The first strobe of a pair is taken as time t and the second as time t+1. When the second strobe arrives, the pair is complete and goes to a word sequencer. If the previous packet is still leaving the block at that point, the new pair is dropped. The frame number still advances and a sticky overflow flag is raised.

The sequencer is a three-state machine:
- `SEQ_IDLE`: no packet is held. A completed pair loads the packet buffer and moves the machine to `SEQ_HEAD`.
- `SEQ_HEAD`: the frame word is offered. When it is accepted, the machine moves to `SEQ_BODY`.
- `SEQ_BODY`: the channel words are offered in turn. When the last one is accepted, the machine returns to `SEQ_IDLE`.

Top module: `acq_packet_assembler`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) has these effects: `out_valid` and `overflow` go low, the frame number returns to 0, and any half-collected pair is discarded. The first strobe after reset is therefore treated as time t, and the first packet after reset carries frame 0.
- R2: Every packet is exactly five words. `out_last` is high on the fifth word only and is never high without `out_valid`. After the fifth word is accepted, `out_valid` is low until a new pair completes.
- R3: Channel i arrives on `smp_data[16*i+15:16*i]`, with i = 0 to 3 in the order converter 1 channel 1, converter 1 channel 2, converter 2 channel 1, converter 2 channel 2. Word k (k = 1 to 4) holds channel k-1: sample t in bits [15:0] and sample t+1 in bits [31:16].
- R4: Strobes alternate between time t and time t+1. If the block is idle, `out_valid` is high in the cycle right after the edge that takes the t+1 strobe, and that word is the frame word.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R6: Word 0 is the frame number, zero-extended to 32 bits. The frame number rises by one for every completed pair and wraps modulo 2^FRAME_W (default FRAME_W = 32).
- R7: A pair that completes while any word of the current packet is still unaccepted is dropped and sets `overflow`. It still advances the frame number. The packet in flight is unaffected. `overflow` never rises while no packet is in flight.
- R8: Once set, `overflow` stays high until reset.
- R9: `smp_data` is ignored in cycles where `smp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | One sample instant for all channels is present |
| smp_data | input | NCH*SMP_W (64) | Samples, channel i in bits [16*i+15:16*i] |
| out_ready | input | 1 | Host accepts the current word |
| out_valid | output | 1 | A packet word is offered |
| out_data | output | 2*SMP_W (32) | Packet word |
| out_last | output | 1 | Marks the fifth word of a packet |
| overflow | output | 1 | Sticky flag: a pair was dropped |

## Verification
The bound checker watches several behaviours on every cycle:
- the output word, valid and last flag stay steady while the host stalls;
- `out_last` appears only on the fifth accepted word of each packet;
- `overflow` is sticky and never rises while the output is idle;
- reset leaves both `out_valid` and `overflow` low.

Other behaviours can only be shown by the bench's scenarios:
- the packed word contents and channel order;
- the t / t+1 placement of samples within each word;
- the frame sequence, including the wrap of a narrow frame counter;
- the gap in frame numbers left by a dropped pair;
- the discarding of a half-collected pair at reset.

// File: rtl/acq_pkg.sv
package acq_pkg;
    localparam int DEF_NCH     = 4;
    localparam int DEF_SMP_W   = 16;
    localparam int DEF_FRAME_W = 32;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HEAD = 2'd1,
        SEQ_BODY = 2'd2
    } seq_state_t;
endpackage

// File: rtl/acq_pair_collector.sv
module acq_pair_collector #(
    parameter int NCH   = 4,
    parameter int SMP_W = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             smp_valid,
    input  logic [NCH*SMP_W-1:0]             smp_data,
    output logic                             pair_done,
    output logic [NCH-1:0][2*SMP_W-1:0]      pair_words
);
    // phase_q low: next strobe is time t; high: next strobe is time t+1
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
        end else if (smp_valid) begin
            phase_q <= ~phase_q;
        end
    end

    assign pair_done = smp_valid & phase_q;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [SMP_W-1:0] early_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                early_q <= '0;
            end else if (smp_valid && !phase_q) begin
                early_q <= smp_data[ch*SMP_W +: SMP_W];
            end
        end

        assign pair_words[ch] = {smp_data[ch*SMP_W +: SMP_W], early_q};
    end
endmodule

// File: rtl/acq_frame_counter.sv
module acq_frame_counter #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    output logic [FRAME_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (step) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/acq_word_sequencer.sv
module acq_word_sequencer
    import acq_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int WORD_W  = 32,
    parameter int FRAME_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        pair_done,
    input  logic [NCH-1:0][WORD_W-1:0]  pair_words,
    input  logic [FRAME_W-1:0]          frame_now,
    input  logic                        out_ready,
    output logic                        out_valid,
    output logic [WORD_W-1:0]           out_data,
    output logic                        out_last,
    output logic                        overflow
);
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NCH - 1);

    seq_state_t                 state_q, state_d;
    logic [NCH-1:0][WORD_W-1:0] buf_q;
    logic [FRAME_W-1:0]         frame_q;
    logic [IDX_W-1:0]           idx_q;
    logic                       ovf_q;
    logic                       busy;
    logic                       load;
    logic [WORD_W-1:0]          head_word;

    assign busy = (state_q != SEQ_IDLE);
    assign load = (state_q == SEQ_IDLE) && pair_done;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (pair_done) state_d = SEQ_HEAD;
            SEQ_HEAD: if (out_ready) state_d = SEQ_BODY;
            SEQ_BODY: if (out_ready && idx_q == IDX_END) state_d = SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // packet buffer, word index, overflow flag
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q   <= '0;
            frame_q <= '0;
            idx_q   <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (load) begin
                buf_q   <= pair_words;
                frame_q <= frame_now;
                idx_q   <= '0;
            end
            if (busy && pair_done) begin
                ovf_q <= 1'b1;
            end
            if (state_q == SEQ_BODY && out_ready) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        head_word = '0;
        head_word[FRAME_W-1:0] = frame_q;
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                out_valid = 1'b0;
            end
            SEQ_HEAD: begin
                out_valid = 1'b1;
                out_data  = head_word;
            end
            SEQ_BODY: begin
                out_valid = 1'b1;
                out_data  = buf_q[idx_q];
                out_last  = (idx_q == IDX_END);
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

    assign overflow = ovf_q;
endmodule

// File: rtl/acq_packet_assembler.sv
module acq_packet_assembler
    import acq_pkg::*;
#(
    parameter int NCH     = DEF_NCH,
    parameter int SMP_W   = DEF_SMP_W,
    parameter int FRAME_W = DEF_FRAME_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   smp_valid,
    input  logic [NCH*SMP_W-1:0]   smp_data,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [2*SMP_W-1:0]     out_data,
    output logic                   out_last,
    output logic                   overflow
);
    localparam int WORD_W = 2 * SMP_W;

    logic                       pair_done;
    logic [NCH-1:0][WORD_W-1:0] pair_words;
    logic [FRAME_W-1:0]         frame_now;

    acq_pair_collector #(
        .NCH   (NCH),
        .SMP_W (SMP_W)
    ) u_collect (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .pair_done  (pair_done),
        .pair_words (pair_words)
    );

    acq_frame_counter #(
        .FRAME_W (FRAME_W)
    ) u_frame (
        .clk   (clk),
        .rst   (rst),
        .step  (pair_done),
        .value (frame_now)
    );

    acq_word_sequencer #(
        .NCH     (NCH),
        .WORD_W  (WORD_W),
        .FRAME_W (FRAME_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pair_done  (pair_done),
        .pair_words (pair_words),
        .frame_now  (frame_now),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .overflow   (overflow)
    );
endmodule

// File: rtl/acq_packet_assembler_chk.sv
module acq_packet_assembler_chk #(
    parameter int NCH   = 4,
    parameter int SMP_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               out_ready,
    input logic               out_valid,
    input logic [2*SMP_W-1:0] out_data,
    input logic               out_last,
    input logic               overflow
);
    localparam int BEAT_W = $clog2(NCH + 1);

    // accepted words of the current packet, tracked at the ports
    logic [BEAT_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (out_valid && out_ready) begin
            beat_q <= (beat_q == BEAT_W'(NCH)) ? '0 : beat_q + 1'b1;
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !overflow));

    assert_last_pos_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (beat_q == BEAT_W'(NCH))));

    assert_last_valid_R2: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_no_idle_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (!overflow && !out_valid) |=> !overflow);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
endmodule

bind acq_packet_assembler acq_packet_assembler_chk #(
    .NCH   (NCH),
    .SMP_W (SMP_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .overflow  (overflow)
);

// File: tb/acq_packet_assembler_bench.sv
module acq_packet_assembler_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [63:0] smp_data = '0;
    logic        out_ready = 1'b0;
    logic        out_valid, out_last, overflow;
    logic [31:0] out_data;
    logic        n_valid, n_last, n_overflow;
    logic [31:0] n_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // 50 MHz clock: 20 time-unit period
    always #10 clk = ~clk;

    acq_packet_assembler u_acq_packet_assembler (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .overflow(overflow)
    );

    // narrow frame counter copy (FRAME_W = 4) to reach the wrap
    acq_packet_assembler #(.FRAME_W(4)) u_acq_packet_assembler_narrow (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .out_ready(out_ready), .out_valid(n_valid), .out_data(n_data),
        .out_last(n_last), .overflow(n_overflow)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] smp(input int p, input int c, input int h);
        int v;
        v = p * 7919 + c * 4001 + h * 1237 + ((p % 2 == 1) ? 32'h8000 : 0);
        return v[15:0];
    endfunction

    task automatic send(input int p, input int h);
        @(negedge clk);
        smp_valid = 1'b1;
        for (int c = 0; c < 4; c++) smp_data[c*16 +: 16] = smp(p, c, h);
        @(negedge clk);
        smp_valid = 1'b0;
        smp_data  = {4{16'hDEAD}}; // R9: junk while smp_valid is low
    endtask

    task automatic send_pair(input int p);
        send(p, 0);
        @(negedge clk);
        send(p, 1);
    endtask

    task automatic read_pkt(input int p, input int frame, input int stall);
        logic [31:0] exp;
        for (int w = 0; w < 5; w++) begin
            exp = (w == 0) ? frame : {smp(p, w - 1, 1), smp(p, w - 1, 0)};
            for (int s = 0; s < stall; s++) begin
                out_ready = 1'b0;
                chk(out_valid && out_data == exp, "R5 stall hold", out_data, exp);
                @(negedge clk);
            end
            out_ready = 1'b1;
            chk(out_valid == 1'b1, "R2 valid", {31'd0, out_valid}, 32'd1);
            chk(out_data == exp, (w == 0) ? "R6 frame word" : "R3 channel word", out_data, exp);
            chk(out_last == (w == 4), "R2 last", {31'd0, out_last}, (w == 4) ? 32'd1 : 32'd0);
            if (w == 0) chk(n_data == 32'(frame % 16), "R6 narrow wrap", n_data, 32'(frame % 16));
            @(negedge clk);
            out_ready = 1'b0;
        end
        chk(!out_valid, "R2 idle after packet", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && !overflow, "R1 reset state", {30'd0, out_valid, overflow}, 32'd0);
        rst = 1'b0;

        // sweep of patterns and stall lengths, frame wraps in narrow copy
        for (int p = 0; p < 20; p++) begin
            send_pair(p);
            chk(out_valid && out_data == 32'(p), "R4 packet start", out_data, 32'(p));
            chk(!overflow, "R7 no overflow", {31'd0, overflow}, 32'd0);
            read_pkt(p, p, p % 3);
        end

        // overflow: second pair completes while first is unaccepted
        send_pair(20);
        send_pair(21);
        chk(overflow, "R7 overflow set", {31'd0, overflow}, 32'd1);
        read_pkt(20, 20, 1);
        send_pair(22);
        read_pkt(22, 22, 0); // frame 21 skipped
        chk(overflow, "R8 sticky", {31'd0, overflow}, 32'd1);

        // reset with a half-collected pair
        send(30, 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(!overflow && !out_valid, "R1 reset clears", {30'd0, out_valid, overflow}, 32'd0);
        send_pair(31);
        read_pkt(31, 0, 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule